// File: doc/BRIEF.md
# Region Memory Protection Checker

This block sits beside a small processor bus and judges every request against eight programmable protection regions. Each region is a naturally aligned, power-of-two window with its own rights for privileged and for unprivileged requests. A large region can switch off any of its eight equal slices, and a request that lands in a switched-off slice falls through to lower-numbered regions. When several regions cover one address, the highest-numbered enabled match decides. If no region matches, a background rule applies. That rule allows privileged requests and faults unprivileged ones.

Software programs the regions and a global enable bit through a simple write port. Each request is presented with a valid strobe. One clock later the block reports allow or fault, along with the region that decided or a flag that marks a background decision.

Top module: `rg_guard`

## Requirements
- R1: Configuration writes use `cfg_sel`. Code 0 writes the base address of region `cfg_region`. Code 1 writes its attribute word. Code 2 writes the global enable from `cfg_wdata[0]`. The attribute word holds the disable mask in bits [7:0], log2 of the size in bits [13:8], the region enable in bit 14, the privileged rights in bits [17:15] and the unprivileged rights in bits [20:18]. A request presented in any cycle after the write sees the new value.
- R2: The response appears on the first rising edge after a request with `req_valid` high, and `rsp_valid` is high for that one cycle. Without a request, all response outputs are low.
- R3: While the global enable is clear, every request is allowed, and `rsp_hit` and `rsp_bg` are both low.
- R4: When enabled regions overlap, the matching region with the highest number decides, and `rsp_region` reports that number with `rsp_hit` high.
- R5: An address that no enabled region matches takes the background rule, with `rsp_bg` high. Privileged requests are allowed and unprivileged requests fault.
- R6: A rights field holds a level in bits [1:0] and an execute grant in bit 2. Level 0 means none, 1 means read-only, and 2 or 3 means read-write. Kind code 0 is a read and needs level 1 or more. Code 1 is a write and needs level 2 or more. Code 2 is an instruction fetch and needs the execute bit. Code 3 is judged as a read.
- R7: Privileged requests are judged only by the privileged rights, and unprivileged requests only by the unprivileged rights.
- R8: A region spans 2^size bytes and ignores base bits below the size. Size codes below 5 act as 5 (32 bytes), and codes above 32 act as 32 (the whole space).
- R9: For sizes of 9 or more (over 256 bytes), address bits [size-1:size-3] select a slice. A set mask bit for that slice makes the region not match, so lower regions or the background decide.
- R10: For sizes of 8 or less, the disable mask is ignored.
- R11: A region with its enable bit clear never matches.
- R12: While `rsp_valid` is high, exactly one of `rsp_allow` and `rsp_fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 base, 1 attributes, 2 global enable |
| cfg_region | input | 3 | Region number for the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_priv | input | 1 | Request is privileged |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Request allowed |
| rsp_fault | output | 1 | Request faulted |
| rsp_hit | output | 1 | A region decided |
| rsp_region | output | 3 | Number of the deciding region |
| rsp_bg | output | 1 | The background rule decided |

## Verification
A corrupted base, size or mask register moves a window edge, so a probe just inside or just outside that edge reports the wrong region or the wrong verdict one clock after it is presented. A wrong priority choice shows as an unexpected `rsp_region` on an overlapping address. A stale global enable shows as a missing background flag. The tests use probes that straddle each window edge and each slice edge, so every such error appears on the response of the very next request.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int ADDR_W    = 32;
  localparam int NREG      = 8;
  localparam int IDX_W     = $clog2(NREG);
  localparam int SIZE_W    = 6;
  localparam int MIN_SIZE  = 5;
  localparam int SUB_SIZE  = 9;

  typedef struct packed {
    logic       x;
    logic [1:0] lvl;
  } perm_t;

  typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_FETCH = 2'd2, K_OTHER = 2'd3} kind_e;

  function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] s);
    if (s < SIZE_W'(MIN_SIZE)) return SIZE_W'(MIN_SIZE);
    if (s > SIZE_W'(ADDR_W))   return SIZE_W'(ADDR_W);
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] upper_mask(input logic [SIZE_W-1:0] s);
    logic [ADDR_W:0] m;
    m = {(ADDR_W+1){1'b1}} << s;
    return m[ADDR_W-1:0];
  endfunction

  function automatic logic [2:0] slice_of(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s);
    logic [ADDR_W-1:0] t;
    t = a >> (s - SIZE_W'(3));
    return t[2:0];
  endfunction

  function automatic logic rights_ok(input perm_t p, input logic [1:0] kind);
    case (kind)
      K_WRITE: return p.lvl >= 2'd2;
      K_FETCH: return p.x;
      default: return p.lvl != 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/rg_region.sv
module rg_region
  import rg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_attr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output perm_t             priv_perm,
  output perm_t             user_perm
);
  logic [ADDR_W-1:0] base_q;
  logic [7:0]        mask_q;
  logic [SIZE_W-1:0] size_q;
  logic              en_q;
  perm_t             pp_q, up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
      pp_q   <= '0;
      up_q   <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_attr) begin
        mask_q <= wdata[7:0];
        size_q <= wdata[13:8];
        en_q   <= wdata[14];
        pp_q   <= perm_t'(wdata[17:15]);
        up_q   <= perm_t'(wdata[20:18]);
      end
    end
  end

  logic [SIZE_W-1:0] eff_size;
  logic              in_window;
  logic              slice_off;

  always_comb begin
    eff_size  = clamp_size(size_q);
    in_window = ((addr ^ base_q) & upper_mask(eff_size)) == '0;
    slice_off = (eff_size >= SIZE_W'(SUB_SIZE)) && mask_q[slice_of(addr, eff_size)];
    hit       = en_q && in_window && !slice_off;
  end

  assign priv_perm = pp_q;
  assign user_perm = up_q;

  a_r11_off_region_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !hit);
  a_r8_window_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_size >= SIZE_W'(MIN_SIZE)) && (eff_size <= SIZE_W'(ADDR_W)));
endmodule

// File: rtl/rg_pick.sv
module rg_pick
  import rg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  a_r4_pick_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> hits[idx]);
  a_r4_nothing_above: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((hits >> idx) == NREG'(1)));
  a_r5_none_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (hits == '0));
endmodule

// File: rtl/rg_guard.sv
module rg_guard
  import rg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [2:0]  cfg_region,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_kind,
  input  logic        req_priv,
  output logic        rsp_valid,
  output logic        rsp_allow,
  output logic        rsp_fault,
  output logic        rsp_hit,
  output logic [2:0]  rsp_region,
  output logic        rsp_bg
);
  logic             glob_en;
  logic [NREG-1:0]  hits;
  perm_t            pp [NREG];
  perm_t            up [NREG];
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         glob_en <= 1'b0;
    else if (cfg_we && cfg_sel == 2'd2) glob_en <= cfg_wdata[0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel_me;
    assign sel_me = cfg_we && (cfg_region == IDX_W'(g));
    rg_region u_region (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_base   (sel_me && cfg_sel == 2'd0),
      .wr_attr   (sel_me && cfg_sel == 2'd1),
      .wdata     (cfg_wdata),
      .addr      (req_addr),
      .hit       (hits[g]),
      .priv_perm (pp[g]),
      .user_perm (up[g])
    );
  end

  rg_pick u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (hits),
    .any   (any_hit),
    .idx   (win_idx)
  );

  perm_t win_perm;
  logic  verdict, dec_hit, dec_bg;

  always_comb begin
    win_perm = req_priv ? pp[win_idx] : up[win_idx];
    dec_hit  = glob_en && any_hit;
    dec_bg   = glob_en && !any_hit;
    if (!glob_en)     verdict = 1'b1;
    else if (any_hit) verdict = rights_ok(win_perm, req_kind);
    else              verdict = req_priv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_bg     <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_allow  <= req_valid && verdict;
      rsp_fault  <= req_valid && !verdict;
      rsp_hit    <= req_valid && dec_hit;
      rsp_region <= (req_valid && dec_hit) ? win_idx : '0;
      rsp_bg     <= req_valid && dec_bg;
    end
  end

  a_r2_valid_one_late: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_allow || rsp_fault || rsp_hit || rsp_bg));
  a_r12_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_allow ^ rsp_fault));
  a_r3_off_allows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !glob_en) |=> (rsp_allow && !rsp_hit && !rsp_bg));
  a_r5_bg_user_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && glob_en && !any_hit && !req_priv) |=> (rsp_fault && rsp_bg));
  a_r5_bg_priv_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && glob_en && !any_hit && req_priv) |=> (rsp_allow && rsp_bg));
endmodule

// File: tb/rg_guard_tb.sv
module rg_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_region = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_fault, rsp_hit, rsp_bg;
  logic [2:0]  rsp_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_region(cfg_region), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_bg(rsp_bg)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FX = 2'd2;
  localparam logic [2:0] P_NONE = 3'b000, P_RO = 3'b001, P_RW = 3'b010,
                         P_RX = 3'b101, P_RWX = 3'b110;

  function automatic logic [31:0] attr(input logic [7:0] mask, input logic [5:0] sz,
                                       input logic en, input logic [2:0] pp, input logic [2:0] upm);
    return {11'd0, upm, pp, en, sz, mask};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [2:0] rg, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_region = rg; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] k,
                       input logic pv, input logic e_allow, input logic e_hit,
                       input logic [2:0] e_rg, input logic e_bg);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_priv = pv;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_allow !== e_allow || rsp_fault !== !e_allow ||
        rsp_hit !== e_hit || rsp_bg !== e_bg || (e_hit && rsp_region !== e_rg)) begin
      fails++;
      $display("FAIL %s addr=%h: got v=%b allow=%b fault=%b hit=%b rg=%0d bg=%b, expected v=1 allow=%b fault=%b hit=%b rg=%0d bg=%b",
               tag, a, rsp_valid, rsp_allow, rsp_fault, rsp_hit, rsp_region, rsp_bg,
               e_allow, !e_allow, e_hit, e_rg, e_bg);
    end
    checks++;
    @(negedge clk);
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_fault !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle after probe: got v=%b allow=%b fault=%b, expected 0 0 0",
               rsp_valid, rsp_allow, rsp_fault);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_hit !== 1'b0 || rsp_bg !== 1'b0) begin
      fails++;
      $display("FAIL R2 reset: got v=%b allow=%b hit=%b bg=%b, expected all 0",
               rsp_valid, rsp_allow, rsp_hit, rsp_bg);
    end
  endtask

  task automatic t_global_off;
    probe("R3 off user read", 32'h0000_1234, RD, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    probe("R3 off user fetch", 32'hF000_0000, FX, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_background;
    wr(2'd2, 3'd0, 32'd1);
    probe("R5 bg user read", 32'h0000_1234, RD, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    probe("R5 bg priv write", 32'h0000_1234, WR, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1);
  endtask

  task automatic t_rights;
    wr(2'd0, 3'd0, 32'h0000_0000);
    wr(2'd1, 3'd0, attr(8'h00, 6'd16, 1'b1, P_RW, P_RO));
    probe("R1 R6 user read ro", 32'h0000_0100, RD, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0);
    probe("R6 user write ro", 32'h0000_0100, WR, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
    probe("R6 user fetch no x", 32'h0000_0100, FX, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
    probe("R7 priv write rw", 32'h0000_0100, WR, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0);
    probe("R6 kind3 as read", 32'h0000_0100, 2'd3, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0);
  endtask

  task automatic t_overlap;
    wr(2'd0, 3'd3, 32'h0000_1000);
    wr(2'd1, 3'd3, attr(8'h00, 6'd12, 1'b1, P_RWX, P_NONE));
    probe("R4 higher wins user", 32'h0000_1800, RD, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0);
    probe("R7 R4 priv fetch", 32'h0000_1800, FX, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0);
    probe("R4 outside upper", 32'h0000_2000, RD, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0);
  endtask

  task automatic t_sizes;
    wr(2'd0, 3'd5, 32'h2000_0ABC);
    wr(2'd1, 3'd5, attr(8'h00, 6'd12, 1'b1, P_NONE, P_RWX));
    probe("R8 low base bits", 32'h2000_0F00, FX, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0);
    probe("R8 window end", 32'h2000_1000, RD, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    probe("R7 priv none", 32'h2000_0010, RD, 1'b1, 1'b0, 1'b1, 3'd5, 1'b0);
    wr(2'd0, 3'd6, 32'h3000_0040);
    wr(2'd1, 3'd6, attr(8'h00, 6'd2, 1'b1, P_RW, P_RW));
    probe("R8 clamp inside", 32'h3000_005F, WR, 1'b0, 1'b1, 1'b1, 3'd6, 1'b0);
    probe("R8 clamp outside", 32'h3000_0060, WR, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
  endtask

  task automatic t_slices;
    wr(2'd0, 3'd4, 32'h4000_0000);
    wr(2'd1, 3'd4, attr(8'h00, 6'd14, 1'b1, P_RO, P_RO));
    wr(2'd0, 3'd7, 32'h4000_0000);
    wr(2'd1, 3'd7, attr(8'hE0, 6'd13, 1'b1, P_RW, P_RW));
    probe("R9 open slice", 32'h4000_0400, WR, 1'b0, 1'b1, 1'b1, 3'd7, 1'b0);
    probe("R9 last open slice", 32'h4000_13FF, WR, 1'b0, 1'b1, 1'b1, 3'd7, 1'b0);
    probe("R9 off slice falls", 32'h4000_1C00, WR, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0);
    probe("R9 first off slice", 32'h4000_1400, RD, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0);
    wr(2'd0, 3'd2, 32'h5000_0000);
    wr(2'd1, 3'd2, attr(8'hFF, 6'd8, 1'b1, P_RO, P_RO));
    probe("R10 small mask ignored", 32'h5000_00F0, RD, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0);
    wr(2'd1, 3'd2, attr(8'h00, 6'd8, 1'b0, P_RO, P_RO));
    probe("R11 disabled region", 32'h5000_00F0, RD, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
  endtask

  task automatic t_whole;
    wr(2'd0, 3'd1, 32'h0);
    wr(2'd1, 3'd1, attr(8'h00, 6'd40, 1'b1, P_RWX, P_NONE));
    probe("R8 whole space", 32'h9000_0000, FX, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0);
    probe("R8 R4 region5 over 1", 32'h2000_0010, FX, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0);
    wr(2'd2, 3'd0, 32'd0);
    probe("R1 R3 global cleared", 32'h9000_0000, WR, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global_off();
    t_background();
    t_rights();
    t_overlap();
    t_sizes();
    t_slices();
    t_whole();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule